// File: doc/BRIEF.md
# Register Write Protection Gate

This block sits in front of a register file and decides, for every host write, whether that write may reach its target. Each target register belongs to a protection group, and the register file supplies that group as a tag with every write. One group covers the monitor channels, and a write to that group also carries the channel index. The block holds two independent protection key registers. A group is locked only while its bit is set in both keys. Writes to the monitor-channel group are further qualified by a per-channel lock register. The block also holds a one-bit bank select register that steers the wider register map.

The four control registers belong to the block itself and can always be written. Clearing either key therefore always unlocks a group. When a write reaches a locked target, the block drops it: the write-enable qualifier stays low and a one-cycle violation pulse follows. The control registers can be read back through a combinational read port. Their addresses, the reset values and the channel count are parameters.

Top module: `regwr_guard`

## Requirements
- R1: After reset, both keys read 0x0E with the default parameters, because the runtime-group bit is always forced to 0. The channel lock register reads 0x0F, because channels 5 to 8 are forced to 0. Bank select reads 0, and `protViol` and `wrAllow` are 0.
- R2: A key register keeps only bit 5 (runtime group), bit 3 (setup group), bit 2 (interrupt-enable group) and bit 1 (monitor-channel group). Every other bit reads 0 whatever was written: writing 0xFF reads back 0x2E, and writing 0xD1 reads back 0x00.
- R3: A write tagged with the setup group (`tgtGroup`=3), the interrupt-enable group (2) or the runtime group (4) is blocked only when that group's bit is 1 in both keys. If either key holds 0 for that group, `wrAllow` follows `wrEn`.
- R4: A write tagged with the monitor-channel group (`tgtGroup`=1) and channel index `tgtChan`=c is blocked only when bit 1 is set in both keys and bit c of the channel lock register is set. Bit 0 of that register is channel 1 and bit 7 is channel 8.
- R5: The bank select register keeps only bit 0, and its other bits read 0. `bankSel` shows the stored bit, and it changes only on a write to the bank select address.
- R6: The key, channel lock and bank select registers accept writes whatever the lock state. Such writes never raise `wrAllow` and never raise `protViol`.
- R7: When a write is blocked, `wrAllow` stays 0 in the cycle of the write. `protViol` is 1 in the cycle after, and only for that one cycle.
- R8: A new key value acts on the very next write: the write that follows a key update is judged against the updated keys.
- R9: Writes tagged with no group (`tgtGroup`=0) are never blocked.
- R10: `wrAllow` is 0 whenever `wrEn` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Host write strobe, one cycle per write |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | DATA_W | Write data |
| tgtGroup | input | 3 | Protection group of the target: 0 none, 1 monitor channel, 2 interrupt enable, 3 setup, 4 runtime |
| tgtChan | input | CH_W | Channel index of the target (0 is channel 1) |
| rdAddr | input | ADDR_W | Read address for the control registers |
| rdData | output | DATA_W | Read data, 0 for any other address |
| wrAllow | output | 1 | Write-enable qualifier for the register file |
| protViol | output | 1 | One-cycle pulse after a blocked write |
| bankSel | output | 1 | Stored bank select bit |

## Verification
The properties assume that `tgtGroup` carries one of the five defined codes. They also assume that `tgtChan` is below the channel count whenever the monitor-channel group is tagged, and that `wrEn` never lasts more than one cycle per write. The bench only drives legal group codes and channel indices 0 to 7. It pulses `wrEn` for exactly one cycle, and at least one idle cycle separates any two writes. Because of that gap, each violation pulse can be observed rising and falling before the next write arrives.

// File: rtl/regwr_guard_pkg.sv
package regwr_guard_pkg;

  typedef enum logic [2:0] {
    GRP_NONE    = 3'd0,
    GRP_CHAN    = 3'd1,
    GRP_IRQEN   = 3'd2,
    GRP_SETUP   = 3'd3,
    GRP_RUNTIME = 3'd4
  } grp_e;

  localparam int unsigned GRP_NUM = 4;
  // lock-vector index -> key bit position: channel, irq-enable, setup, runtime
  localparam int unsigned GRP_BITPOS [GRP_NUM] = '{1, 2, 3, 5};
  localparam int unsigned IDX_CHAN    = 0;
  localparam int unsigned IDX_IRQEN   = 1;
  localparam int unsigned IDX_SETUP   = 2;
  localparam int unsigned IDX_RUNTIME = 3;

  typedef struct packed {
    logic ldKeyA;
    logic ldKeyB;
    logic ldChan;
    logic ldBank;
    logic rdKeyA;
    logic rdKeyB;
    logic rdChan;
    logic rdBank;
  } guard_strb_t;

endpackage

// File: rtl/regwr_guard_regs.sv
module regwr_guard_regs
  import regwr_guard_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned NUM_CH   = 8,
  parameter logic [DATA_W-1:0] KEY_RST  = 8'h0E,
  parameter logic [NUM_CH-1:0] CHAN_RST = 8'h0F
) (
  input  logic                clk,
  input  logic                rstN,
  input  guard_strb_t         strb,
  input  logic [DATA_W-1:0]   wrData,
  output logic [GRP_NUM-1:0]  grpLock,
  output logic [NUM_CH-1:0]   chanLock,
  output logic                bankSel,
  output logic [DATA_W-1:0]   rdData
);

  function automatic logic [DATA_W-1:0] keyMaskF();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < GRP_NUM; i++) m[GRP_BITPOS[i]] = 1'b1;
    return m;
  endfunction

  function automatic logic [NUM_CH-1:0] chanKeepF();
    logic [NUM_CH-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_CH && i < 4; i++) m[i] = 1'b1;
    return m;
  endfunction

  localparam logic [DATA_W-1:0] KEY_MASK     = keyMaskF();
  localparam logic [DATA_W-1:0] RUNTIME_BIT  = DATA_W'(1) << GRP_BITPOS[IDX_RUNTIME];
  localparam logic [DATA_W-1:0] KEY_RST_EFF  = KEY_RST & KEY_MASK & ~RUNTIME_BIT;
  localparam logic [NUM_CH-1:0] CHAN_RST_EFF = CHAN_RST & chanKeepF();

  logic [DATA_W-1:0] keyA;
  logic [DATA_W-1:0] keyB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyA     <= KEY_RST_EFF;
      keyB     <= KEY_RST_EFF;
      chanLock <= CHAN_RST_EFF;
      bankSel  <= 1'b0;
    end else begin
      if (strb.ldKeyA) keyA     <= wrData & KEY_MASK;
      if (strb.ldKeyB) keyB     <= wrData & KEY_MASK;
      if (strb.ldChan) chanLock <= wrData[NUM_CH-1:0];
      if (strb.ldBank) bankSel  <= wrData[0];
    end
  end

  for (genvar g = 0; g < GRP_NUM; g++) begin : g_lock
    assign grpLock[g] = keyA[GRP_BITPOS[g]] & keyB[GRP_BITPOS[g]];
  end

  always_comb begin
    rdData = '0;
    if (strb.rdKeyA) rdData = keyA;
    if (strb.rdKeyB) rdData = keyB;
    if (strb.rdChan) rdData = DATA_W'(chanLock);
    if (strb.rdBank) rdData = DATA_W'(bankSel);
  end

endmodule

// File: rtl/regwr_guard_ctrl.sv
module regwr_guard_ctrl
  import regwr_guard_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned CH_W   = $clog2(NUM_CH),
  parameter logic [ADDR_W-1:0] KEYA_ADDR = 8'hC4,
  parameter logic [ADDR_W-1:0] KEYB_ADDR = 8'hC5,
  parameter logic [ADDR_W-1:0] CHAN_ADDR = 8'hC6,
  parameter logic [ADDR_W-1:0] BANK_ADDR = 8'hC0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [ADDR_W-1:0]   rdAddr,
  input  grp_e                tgtGroup,
  input  logic [CH_W-1:0]     tgtChan,
  input  logic [GRP_NUM-1:0]  grpLock,
  input  logic [NUM_CH-1:0]   chanLock,
  output guard_strb_t         strb,
  output logic                wrAllow,
  output logic                protViol
);

  logic ctrlHit;
  logic tgtLocked;
  logic blocked;

  assign ctrlHit = (wrAddr == KEYA_ADDR) || (wrAddr == KEYB_ADDR) ||
                   (wrAddr == CHAN_ADDR) || (wrAddr == BANK_ADDR);

  always_comb begin
    strb        = '0;
    strb.ldKeyA = wrEn && (wrAddr == KEYA_ADDR);
    strb.ldKeyB = wrEn && (wrAddr == KEYB_ADDR);
    strb.ldChan = wrEn && (wrAddr == CHAN_ADDR);
    strb.ldBank = wrEn && (wrAddr == BANK_ADDR);
    strb.rdKeyA = (rdAddr == KEYA_ADDR);
    strb.rdKeyB = (rdAddr == KEYB_ADDR);
    strb.rdChan = (rdAddr == CHAN_ADDR);
    strb.rdBank = (rdAddr == BANK_ADDR);
  end

  always_comb begin
    case (tgtGroup)
      GRP_CHAN:    tgtLocked = grpLock[IDX_CHAN] & chanLock[tgtChan];
      GRP_IRQEN:   tgtLocked = grpLock[IDX_IRQEN];
      GRP_SETUP:   tgtLocked = grpLock[IDX_SETUP];
      GRP_RUNTIME: tgtLocked = grpLock[IDX_RUNTIME];
      default:     tgtLocked = 1'b0;
    endcase
  end

  assign blocked = wrEn && !ctrlHit && tgtLocked;
  assign wrAllow = wrEn && !ctrlHit && !tgtLocked;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) protViol <= 1'b0;
    else       protViol <= blocked;
  end

endmodule

// File: rtl/regwr_guard.sv
module regwr_guard
  import regwr_guard_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned CH_W   = $clog2(NUM_CH),
  parameter logic [ADDR_W-1:0] KEYA_ADDR = 8'hC4,
  parameter logic [ADDR_W-1:0] KEYB_ADDR = 8'hC5,
  parameter logic [ADDR_W-1:0] CHAN_ADDR = 8'hC6,
  parameter logic [ADDR_W-1:0] BANK_ADDR = 8'hC0,
  parameter logic [DATA_W-1:0] KEY_RST   = 8'h0E,
  parameter logic [NUM_CH-1:0] CHAN_RST  = 8'h0F
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [2:0]        tgtGroup,
  input  logic [CH_W-1:0]   tgtChan,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              wrAllow,
  output logic              protViol,
  output logic              bankSel
);

  guard_strb_t        strb;
  logic [GRP_NUM-1:0] grpLock;
  logic [NUM_CH-1:0]  chanLock;

  regwr_guard_ctrl #(
    .ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .CH_W(CH_W),
    .KEYA_ADDR(KEYA_ADDR), .KEYB_ADDR(KEYB_ADDR),
    .CHAN_ADDR(CHAN_ADDR), .BANK_ADDR(BANK_ADDR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .tgtGroup(grp_e'(tgtGroup)), .tgtChan(tgtChan),
    .grpLock(grpLock), .chanLock(chanLock),
    .strb(strb), .wrAllow(wrAllow), .protViol(protViol)
  );

  regwr_guard_regs #(
    .DATA_W(DATA_W), .NUM_CH(NUM_CH), .KEY_RST(KEY_RST), .CHAN_RST(CHAN_RST)
  ) u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .grpLock(grpLock), .chanLock(chanLock), .bankSel(bankSel), .rdData(rdData)
  );

endmodule

// File: rtl/regwr_guard_chk.sv
module regwr_guard_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] KEYA_ADDR = 8'hC4,
  parameter logic [ADDR_W-1:0] KEYB_ADDR = 8'hC5,
  parameter logic [ADDR_W-1:0] CHAN_ADDR = 8'hC6,
  parameter logic [ADDR_W-1:0] BANK_ADDR = 8'hC0
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [2:0]        tgtGroup,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [DATA_W-1:0] rdData,
  input logic              wrAllow,
  input logic              protViol,
  input logic              bankSel
);

  logic ctrlHit;
  logic refused;
  assign ctrlHit = (wrAddr == KEYA_ADDR) || (wrAddr == KEYB_ADDR) ||
                   (wrAddr == CHAN_ADDR) || (wrAddr == BANK_ADDR);
  assign refused = wrEn && !ctrlHit && !wrAllow;

  a_r10_idle_no_allow: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> !wrAllow);

  a_r7_viol_after_block: assert property (@(posedge clk) disable iff (!rstN)
    refused |=> protViol);

  a_r7_viol_has_cause: assert property (@(posedge clk) disable iff (!rstN)
    protViol |-> $past(refused));

  a_r9_untagged_passes: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !ctrlHit && tgtGroup == 3'd0) |-> wrAllow);

  a_r6_ctrl_no_allow: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && ctrlHit) |-> !wrAllow);

  a_r6_ctrl_no_viol: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && ctrlHit) |=> !protViol);

  a_r5_bank_holds: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && wrAddr == BANK_ADDR) |=> $stable(bankSel));

  a_r2_key_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr == KEYA_ADDR || rdAddr == KEYB_ADDR) |-> (rdData & 8'hD1) == '0);

  a_r5_bank_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr == BANK_ADDR) |-> (rdData >> 1) == '0);

endmodule

bind regwr_guard regwr_guard_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .KEYA_ADDR(KEYA_ADDR), .KEYB_ADDR(KEYB_ADDR),
  .CHAN_ADDR(CHAN_ADDR), .BANK_ADDR(BANK_ADDR)
) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .tgtGroup(tgtGroup),
  .rdAddr(rdAddr), .rdData(rdData), .wrAllow(wrAllow), .protViol(protViol),
  .bankSel(bankSel)
);

// File: tb/regwr_guard_tb.sv
module regwr_guard_tb;

  localparam logic [7:0] A_KEYA = 8'hC4;
  localparam logic [7:0] A_KEYB = 8'hC5;
  localparam logic [7:0] A_CHAN = 8'hC6;
  localparam logic [7:0] A_BANK = 8'hC0;
  localparam logic [7:0] A_DATA = 8'h40;

  localparam logic [2:0] G_NONE = 3'd0, G_CHAN = 3'd1, G_IRQ = 3'd2,
                         G_SETUP = 3'd3, G_RUN = 3'd4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [2:0] tgtGroup = '0;
  logic [2:0] tgtChan = '0;
  logic [7:0] rdAddr = '0;
  logic [7:0] rdData;
  logic       wrAllow, protViol, bankSel;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  regwr_guard u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .tgtGroup(tgtGroup), .tgtChan(tgtChan), .rdAddr(rdAddr), .rdData(rdData),
    .wrAllow(wrAllow), .protViol(protViol), .bankSel(bankSel)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one write; checks allow, the following pulse and its end
  task automatic doWrite(input string req, input logic [7:0] a, input logic [7:0] d,
                         input logic [2:0] g, input logic [2:0] c,
                         input logic expAllow, input logic expViol);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d; tgtGroup = g; tgtChan = c;
    #1 check({req, " allow"}, wrAllow, expAllow);
    @(negedge clk);
    wrEn = 1'b0;
    check({req, " viol"}, protViol, expViol);
    @(negedge clk);
    check({req, " viol end"}, protViol, 1'b0);
  endtask

  task automatic readCheck(input string req, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk);
    rdAddr = a;
    #1 check(req, rdData, exp);
  endtask

  task automatic t_reset;
    readCheck("R1 keyA reset", A_KEYA, 8'h0E);
    readCheck("R1 keyB reset", A_KEYB, 8'h0E);
    readCheck("R1 chan reset", A_CHAN, 8'h0F);
    readCheck("R1 bank reset", A_BANK, 8'h00);
    check("R1 bankSel reset", bankSel, 1'b0);
    check("R1 protViol reset", protViol, 1'b0);
    check("R10 wrAllow idle", wrAllow, 1'b0);
  endtask

  task automatic t_groups;
    doWrite("R3 R7 setup locked", A_DATA, 8'h11, G_SETUP, 3'd0, 1'b0, 1'b1);
    doWrite("R3 irq locked", A_DATA, 8'h12, G_IRQ, 3'd0, 1'b0, 1'b1);
    doWrite("R3 runtime open", A_DATA, 8'h13, G_RUN, 3'd0, 1'b1, 1'b0);
    doWrite("R9 untagged", A_DATA, 8'h14, G_NONE, 3'd0, 1'b1, 1'b0);
  endtask

  task automatic t_channels;
    doWrite("R4 ch1 locked", A_DATA, 8'h21, G_CHAN, 3'd0, 1'b0, 1'b1);
    doWrite("R4 ch4 locked", A_DATA, 8'h22, G_CHAN, 3'd3, 1'b0, 1'b1);
    doWrite("R4 ch6 open", A_DATA, 8'h23, G_CHAN, 3'd5, 1'b1, 1'b0);
  endtask

  task automatic t_ctrl_always;
    doWrite("R6 chan write", A_CHAN, 8'hFF, G_SETUP, 3'd0, 1'b0, 1'b0);
    readCheck("R6 chan readback", A_CHAN, 8'hFF);
    doWrite("R4 ch6 now locked", A_DATA, 8'h24, G_CHAN, 3'd5, 1'b0, 1'b1);
    doWrite("R4 ch8 now locked", A_DATA, 8'h25, G_CHAN, 3'd7, 1'b0, 1'b1);
  endtask

  task automatic t_keys;
    doWrite("R6 keyA write", A_KEYA, 8'hFF, G_NONE, 3'd0, 1'b0, 1'b0);
    readCheck("R2 keyA 0xFF", A_KEYA, 8'h2E);
    doWrite("R3 runtime one key", A_DATA, 8'h31, G_RUN, 3'd0, 1'b1, 1'b0);
    doWrite("R6 keyB write", A_KEYB, 8'hFF, G_RUN, 3'd0, 1'b0, 1'b0);
    readCheck("R2 keyB 0xFF", A_KEYB, 8'h2E);
    doWrite("R8 runtime next write", A_DATA, 8'h32, G_RUN, 3'd0, 1'b0, 1'b1);
  endtask

  task automatic t_unlock;
    doWrite("R6 keyA clear", A_KEYA, 8'h00, G_NONE, 3'd0, 1'b0, 1'b0);
    doWrite("R8 R3 setup open", A_DATA, 8'h41, G_SETUP, 3'd0, 1'b1, 1'b0);
    doWrite("R4 ch1 group open", A_DATA, 8'h42, G_CHAN, 3'd0, 1'b1, 1'b0);
    doWrite("R3 irq open", A_DATA, 8'h43, G_IRQ, 3'd0, 1'b1, 1'b0);
    doWrite("R2 keyB reserved", A_KEYB, 8'hD1, G_NONE, 3'd0, 1'b0, 1'b0);
    readCheck("R2 keyB 0xD1", A_KEYB, 8'h00);
  endtask

  task automatic t_bank;
    doWrite("R5 bank write", A_BANK, 8'hFF, G_NONE, 3'd0, 1'b0, 1'b0);
    readCheck("R5 bank 0xFF", A_BANK, 8'h01);
    check("R5 bankSel set", bankSel, 1'b1);
    doWrite("R5 other write", A_DATA, 8'h00, G_NONE, 3'd0, 1'b1, 1'b0);
    check("R5 bankSel kept", bankSel, 1'b1);
    doWrite("R5 bank even", A_BANK, 8'h02, G_NONE, 3'd0, 1'b0, 1'b0);
    readCheck("R5 bank 0x02", A_BANK, 8'h00);
    check("R5 bankSel clear", bankSel, 1'b0);
  endtask

  task automatic t_idle;
    @(negedge clk);
    wrAddr = A_DATA; tgtGroup = G_NONE;
    #1 check("R10 no strobe", wrAllow, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_groups();
    t_channels();
    t_ctrl_always();
    t_keys();
    t_unlock();
    t_bank();
    t_idle();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        nChecks++;
        nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule